// File: doc/BRIEF.md
# Product-Term Sum Cascade Cell

This block is one configurable logic cell of a programmable logic array. It forms five product terms from a shared vector of array inputs. Each term has its own pair of AND masks, one selecting true literals and one selecting complemented literals. A steering field decides which of those terms take part in the cell's OR sum. The sum is also merged with a cascade input from the neighbouring cell. The merged sum leaves on a cascade output, so a row of up to eight cells can build a sum of up to forty terms.

The merged sum passes through an XOR stage. The second XOR input is a constant (for polarity, or for DeMorgan-minimised logic) or one of the cell's own product terms. The pin value and the feedback value each choose, independently, between that combinational result and a registered value. The registered value arrives from a storage element outside the cell.

The cell also picks an output enable from five sources. It drives a foldback bit onto a regional bus: the inverse of one product term. All configuration is a static input word that is loaded once. The cell has no clock of its own and is purely combinational.

Top module: `ptc_cell`

## Requirements
- R1: Product term p is the AND of `arr_in[i]` for every set bit `cfg_lit_pos[p*N_IN+i]` and of `~arr_in[i]` for every set bit `cfg_lit_neg[p*N_IN+i]`. A term with no mask bits set is 1. A term with the same input set in both masks is 0.
- R2: Term p enters the OR sum only when `cfg_sum_en[p]` is 1. A term left out of the sum can still be used as the XOR, output-enable or foldback source.
- R3: `chain_out` equals the OR of the enabled terms, ORed with `chain_in` when `cfg_chain_en` is 1. When `cfg_chain_en` is 0, `chain_in` has no effect on any output. A chained cell therefore sums the terms of every upstream cell.
- R4: `cfg_xor_src` selects the second XOR input: 0 gives constant 0, 1 gives constant 1, 2 gives term `cfg_xor_idx`, and 3 gives constant 0. The combinational result is `chain_out` XOR that input.
- R5: `pin_out` is `reg_q` when `cfg_pin_reg` is 1. Otherwise it is the combinational result.
- R6: `fb_out` is `reg_q` when `cfg_fb_reg` is 1. Otherwise it is the combinational result. This choice is independent of `cfg_pin_reg`.
- R7: `cfg_oe_src` selects `oe_out`: 0 gives 0, 1 gives 1, 2 gives `oe_pin[0]`, 3 gives `oe_pin[1]`, and 4 gives term `cfg_oe_idx`. Codes 5 to 7 give 0.
- R8: `fold_out` is the inverse of term `cfg_fold_idx`.
- R9: A term index of N_PT or above selects a 0 term. Through R4 and R7 it therefore yields 0, and through R8 it makes `fold_out` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arr_in | input | N_IN | Array input signals seen by every product term |
| oe_pin | input | 2 | Two dedicated output-enable inputs |
| chain_in | input | 1 | Cascade sum from the upstream cell |
| reg_q | input | 1 | Value held by the external storage element |
| cfg_lit_pos | input | N_PT*N_IN | True-literal masks, term p at bits p*N_IN upward |
| cfg_lit_neg | input | N_PT*N_IN | Complement-literal masks, same layout |
| cfg_sum_en | input | N_PT | Per-term inclusion in the OR sum |
| cfg_chain_en | input | 1 | Merge `chain_in` into the sum |
| cfg_xor_src | input | 2 | Second XOR input source |
| cfg_xor_idx | input | IDX_W | Term index for the XOR input |
| cfg_oe_src | input | 3 | Output-enable source |
| cfg_oe_idx | input | IDX_W | Term index for the output enable |
| cfg_fold_idx | input | IDX_W | Term index for the foldback bit |
| cfg_pin_reg | input | 1 | Pin takes the registered value |
| cfg_fb_reg | input | 1 | Feedback takes the registered value |
| chain_out | output | 1 | Merged sum toward the downstream cell |
| pin_out | output | 1 | Output value for the pin |
| fb_out | output | 1 | Feedback value toward the array |
| oe_out | output | 1 | Output enable |
| fold_out | output | 1 | Inverted product term for the regional bus |

## Verification
The bench aims at the term corner cases.

- An empty mask must give 1. A design that ANDed over nothing as 0 would lose always-true terms.
- A literal present in both masks must give 0. A design that let one mask override the other would turn such a term into a plain literal.
- A term steered away from the sum must still drive the XOR. A design that cleared steered terms would lose that control use.
- A disabled cascade input must not reach any output.
- Out-of-range term indices and reserved mode codes must resolve to the documented constants rather than to a wrapped index.
- The pin and feedback selects are flipped independently, to catch a design that shares one select between them.

Random configurations with sparse masks keep terms near the true/false boundary.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

   typedef enum logic [1:0] {
      XSRC_ZERO = 2'd0,
      XSRC_ONE  = 2'd1,
      XSRC_TERM = 2'd2,
      XSRC_RSVD = 2'd3
   } xor_src_e;

   typedef enum logic [2:0] {
      OESRC_OFF  = 3'd0,
      OESRC_ON   = 3'd1,
      OESRC_PIN0 = 3'd2,
      OESRC_PIN1 = 3'd3,
      OESRC_TERM = 3'd4
   } oe_src_e;

   localparam int MAX_CHAIN = 8;

endpackage

// File: rtl/ptc_term_array.sv
module ptc_term_array #(
   parameter int N_IN = 40,
   parameter int N_PT = 5
) (
   input  logic [N_IN-1:0]      arr_in,
   input  logic [N_PT*N_IN-1:0] lit_pos,
   input  logic [N_PT*N_IN-1:0] lit_neg,
   output logic [N_PT-1:0]      terms
);

   for (genvar p = 0; p < N_PT; p++) begin : g_term
      logic [N_IN-1:0] pos_m;
      logic [N_IN-1:0] neg_m;
      assign pos_m = lit_pos[p*N_IN +: N_IN];
      assign neg_m = lit_neg[p*N_IN +: N_IN];
      assign terms[p] = &((~pos_m | arr_in) & (~neg_m | ~arr_in));

      always_comb begin
         if ((pos_m & neg_m) != '0)
            AST_TERM_CONFLICT: assert (terms[p] == 1'b0); // R1
      end
   end

endmodule

// File: rtl/ptc_term_pick.sv
module ptc_term_pick #(
   parameter int N_PT  = 5,
   parameter int IDX_W = 3
) (
   input  logic [N_PT-1:0]  terms,
   input  logic [IDX_W-1:0] idx,
   output logic             picked
);

   always_comb begin
      picked = 1'b0;
      for (int k = 0; k < N_PT; k++) begin
         if (idx == IDX_W'(k)) picked = terms[k];
      end
   end

   always_comb begin
      if (32'(idx) >= N_PT)
         AST_IDX_RANGE: assert (picked == 1'b0); // R9
   end

endmodule

// File: rtl/ptc_sum_cascade.sv
module ptc_sum_cascade #(
   parameter int N_PT        = 5,
   parameter bit HAS_CASCADE = 1'b1
) (
   input  logic [N_PT-1:0] terms,
   input  logic [N_PT-1:0] sum_en,
   input  logic            chain_en,
   input  logic            chain_in,
   output logic            sum_out
);

   logic local_sum;
   assign local_sum = |(terms & sum_en);

   if (HAS_CASCADE) begin : g_chain
      assign sum_out = local_sum | (chain_en & chain_in);
   end else begin : g_nochain
      logic unused_chain;
      assign unused_chain = chain_en ^ chain_in;
      assign sum_out = local_sum;
   end

   always_comb begin
      if (HAS_CASCADE && chain_en && chain_in)
         AST_CHAIN_PASS: assert (sum_out == 1'b1); // R3
      if (sum_en == '0 && !(chain_en && chain_in))
         AST_EMPTY_SUM: assert (sum_out == 1'b0); // R2
   end

endmodule

// File: rtl/ptc_out_stage.sv
module ptc_out_stage
   import ptc_pkg::*;
(
   input  logic     sum_in,
   input  xor_src_e xor_src,
   input  logic     xor_term,
   input  logic     reg_q,
   input  logic     pin_reg,
   input  logic     fb_reg,
   output logic     pin_out,
   output logic     fb_out
);

   logic xor_b;
   logic comb_v;

   always_comb begin
      unique case (xor_src)
         XSRC_ONE:  xor_b = 1'b1;
         XSRC_TERM: xor_b = xor_term;
         default:   xor_b = 1'b0;
      endcase
   end

   assign comb_v  = sum_in ^ xor_b;
   assign pin_out = pin_reg ? reg_q : comb_v;
   assign fb_out  = fb_reg  ? reg_q : comb_v;

   always_comb begin
      if (xor_src == XSRC_ONE && !pin_reg)
         AST_POLARITY_FLIP: assert (pin_out != sum_in); // R4
      if (!pin_reg && !fb_reg)
         AST_PIN_FB_AGREE: assert (pin_out == fb_out); // R6
   end

endmodule

// File: rtl/ptc_oe_select.sv
module ptc_oe_select
   import ptc_pkg::*;
(
   input  logic [2:0] oe_src,
   input  logic [1:0] oe_pin,
   input  logic       oe_term,
   output logic       oe_out
);

   always_comb begin
      case (oe_src)
         3'(OESRC_ON):   oe_out = 1'b1;
         3'(OESRC_PIN0): oe_out = oe_pin[0];
         3'(OESRC_PIN1): oe_out = oe_pin[1];
         3'(OESRC_TERM): oe_out = oe_term;
         default:        oe_out = 1'b0;
      endcase
   end

   always_comb begin
      if (oe_src == 3'(OESRC_OFF) || oe_src > 3'(OESRC_TERM))
         AST_OE_OFF: assert (oe_out == 1'b0); // R7
   end

endmodule

// File: rtl/ptc_cell.sv
module ptc_cell
   import ptc_pkg::*;
#(
   parameter int N_IN        = 40,
   parameter int N_PT        = 5,
   parameter bit HAS_CASCADE = 1'b1,
   localparam int IDX_W      = $clog2(N_PT)
) (
   input  logic [N_IN-1:0]      arr_in,
   input  logic [1:0]           oe_pin,
   input  logic                 chain_in,
   input  logic                 reg_q,
   input  logic [N_PT*N_IN-1:0] cfg_lit_pos,
   input  logic [N_PT*N_IN-1:0] cfg_lit_neg,
   input  logic [N_PT-1:0]      cfg_sum_en,
   input  logic                 cfg_chain_en,
   input  logic [1:0]           cfg_xor_src,
   input  logic [IDX_W-1:0]     cfg_xor_idx,
   input  logic [2:0]           cfg_oe_src,
   input  logic [IDX_W-1:0]     cfg_oe_idx,
   input  logic [IDX_W-1:0]     cfg_fold_idx,
   input  logic                 cfg_pin_reg,
   input  logic                 cfg_fb_reg,
   output logic                 chain_out,
   output logic                 pin_out,
   output logic                 fb_out,
   output logic                 oe_out,
   output logic                 fold_out
);

   if (N_IN < 1 || N_IN > 256) begin : g_bad_nin
      $error("ptc_cell: N_IN out of range");
   end
   if (N_PT < 2 || N_PT > 8) begin : g_bad_npt
      $error("ptc_cell: N_PT out of range");
   end
   if (N_PT * MAX_CHAIN > 64) begin : g_bad_chain
      $error("ptc_cell: chained sum too wide");
   end

   logic [N_PT-1:0] terms;
   logic            xor_term;
   logic            oe_term;
   logic            fold_term;

   ptc_term_array #(.N_IN(N_IN), .N_PT(N_PT)) u_terms (
      .arr_in (arr_in),
      .lit_pos(cfg_lit_pos),
      .lit_neg(cfg_lit_neg),
      .terms  (terms)
   );

   ptc_sum_cascade #(.N_PT(N_PT), .HAS_CASCADE(HAS_CASCADE)) u_sum (
      .terms   (terms),
      .sum_en  (cfg_sum_en),
      .chain_en(cfg_chain_en),
      .chain_in(chain_in),
      .sum_out (chain_out)
   );

   ptc_term_pick #(.N_PT(N_PT), .IDX_W(IDX_W)) u_pick_xor (
      .terms(terms), .idx(cfg_xor_idx), .picked(xor_term)
   );
   ptc_term_pick #(.N_PT(N_PT), .IDX_W(IDX_W)) u_pick_oe (
      .terms(terms), .idx(cfg_oe_idx), .picked(oe_term)
   );
   ptc_term_pick #(.N_PT(N_PT), .IDX_W(IDX_W)) u_pick_fold (
      .terms(terms), .idx(cfg_fold_idx), .picked(fold_term)
   );

   ptc_out_stage u_out (
      .sum_in  (chain_out),
      .xor_src (xor_src_e'(cfg_xor_src)),
      .xor_term(xor_term),
      .reg_q   (reg_q),
      .pin_reg (cfg_pin_reg),
      .fb_reg  (cfg_fb_reg),
      .pin_out (pin_out),
      .fb_out  (fb_out)
   );

   ptc_oe_select u_oe (
      .oe_src (cfg_oe_src),
      .oe_pin (oe_pin),
      .oe_term(oe_term),
      .oe_out (oe_out)
   );

   assign fold_out = ~fold_term;

   always_comb begin
      if (cfg_pin_reg)
         AST_PIN_REG: assert (pin_out == reg_q); // R5
      if (32'(cfg_fold_idx) >= N_PT)
         AST_FOLD_RANGE: assert (fold_out == 1'b1); // R8
   end

endmodule

// File: tb/ptc_cell_bench.sv
module ptc_cell_bench;

   localparam int N_IN  = 40;
   localparam int N_PT  = 5;
   localparam int IDX_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [N_IN-1:0]      arr_in;
   logic [1:0]           oe_pin;
   logic                 chain_in, reg_q;
   logic [N_IN-1:0]      mpos [N_PT];
   logic [N_IN-1:0]      mneg [N_PT];
   logic [N_PT*N_IN-1:0] lit_pos, lit_neg;
   logic [N_PT-1:0]      sum_en;
   logic                 chain_en, pin_reg, fb_reg;
   logic [1:0]           xor_src;
   logic [2:0]           oe_src;
   logic [IDX_W-1:0]     xor_idx, oe_idx, fold_idx;
   logic chain_out, pin_out, fb_out, oe_out, fold_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always_comb begin
      for (int p = 0; p < N_PT; p++) begin
         lit_pos[p*N_IN +: N_IN] = mpos[p];
         lit_neg[p*N_IN +: N_IN] = mneg[p];
      end
   end

   ptc_cell #(.N_IN(N_IN), .N_PT(N_PT)) u_ptc_cell (
      .arr_in(arr_in), .oe_pin(oe_pin), .chain_in(chain_in), .reg_q(reg_q),
      .cfg_lit_pos(lit_pos), .cfg_lit_neg(lit_neg), .cfg_sum_en(sum_en),
      .cfg_chain_en(chain_en), .cfg_xor_src(xor_src), .cfg_xor_idx(xor_idx),
      .cfg_oe_src(oe_src), .cfg_oe_idx(oe_idx), .cfg_fold_idx(fold_idx),
      .cfg_pin_reg(pin_reg), .cfg_fb_reg(fb_reg),
      .chain_out(chain_out), .pin_out(pin_out), .fb_out(fb_out),
      .oe_out(oe_out), .fold_out(fold_out)
   );

   // Reference model derived from the requirements
   function automatic bit m_term(int p);
      for (int i = 0; i < N_IN; i++) begin
         if (mpos[p][i] && !arr_in[i]) return 1'b0;
         if (mneg[p][i] &&  arr_in[i]) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic bit m_pick(logic [IDX_W-1:0] idx);
      if (int'(idx) >= N_PT) return 1'b0;
      return m_term(int'(idx));
   endfunction

   function automatic bit m_sum();
      bit s = 1'b0;
      for (int p = 0; p < N_PT; p++) if (sum_en[p] && m_term(p)) s = 1'b1;
      return s | (chain_en & chain_in);
   endfunction

   function automatic bit m_comb();
      bit x;
      case (xor_src)
         2'd1:    x = 1'b1;
         2'd2:    x = m_pick(xor_idx);
         default: x = 1'b0;
      endcase
      return m_sum() ^ x;
   endfunction

   function automatic bit m_oe();
      case (oe_src)
         3'd1:    return 1'b1;
         3'd2:    return oe_pin[0];
         3'd3:    return oe_pin[1];
         3'd4:    return m_pick(oe_idx);
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      #2;
      chk({tag, " R3 chain_out"}, chain_out, m_sum());
      chk({tag, " R5 pin_out"},   pin_out,   pin_reg ? reg_q : m_comb());
      chk({tag, " R6 fb_out"},    fb_out,    fb_reg ? reg_q : m_comb());
      chk({tag, " R7 oe_out"},    oe_out,    m_oe());
      chk({tag, " R8 fold_out"},  fold_out,  ~m_pick(fold_idx));
      @(posedge clk);
   endtask

   task automatic clear_cfg();
      for (int p = 0; p < N_PT; p++) begin
         mpos[p] = '0;
         mneg[p] = '0;
      end
      sum_en = '0; chain_en = 0; pin_reg = 0; fb_reg = 0;
      xor_src = 0; oe_src = 0; xor_idx = 0; oe_idx = 0; fold_idx = 0;
      arr_in = '0; oe_pin = 0; chain_in = 0; reg_q = 0;
   endtask

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      clear_cfg();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk);

      // Reset-state configuration: everything off
      #2;
      chk("R3 idle chain_out", chain_out, 1'b0);
      chk("R7 idle oe_out", oe_out, 1'b0);
      chk("R8 idle fold of empty term", fold_out, 1'b0);
      @(posedge clk);

      // R1 empty mask term is 1
      sum_en = 5'b00001;
      #2 chk("R1 empty term", chain_out, 1'b1);
      @(posedge clk);

      // R1 conflicting literal gives 0
      mpos[0][3] = 1; mneg[0][3] = 1; arr_in[3] = 1;
      #2 chk("R1 conflict term", chain_out, 1'b0);
      @(posedge clk);

      // R1 true and complement literals
      clear_cfg();
      sum_en = 5'b00100; mpos[2][7] = 1; mneg[2][9] = 1;
      arr_in[7] = 1;
      #2 chk("R1 literals met", chain_out, 1'b1);
      @(posedge clk);
      arr_in[9] = 1;
      #2 chk("R1 complement fails", chain_out, 1'b0);
      @(posedge clk);

      // R2 steered term excluded from sum, still drives XOR
      clear_cfg();
      sum_en = 5'b00000; xor_src = 2'd2; xor_idx = 3'd1;
      #2 chk("R2 steered term out of sum", chain_out, 1'b0);
      chk("R2 steered term drives xor", pin_out, 1'b1);
      @(posedge clk);

      // R3 disabled cascade ignored, enabled cascade passed
      clear_cfg();
      chain_in = 1;
      #2 chk("R3 chain disabled", chain_out, 1'b0);
      chk("R3 chain disabled pin", pin_out, 1'b0);
      @(posedge clk);
      chain_en = 1;
      #2 chk("R3 chain enabled", chain_out, 1'b1);
      @(posedge clk);

      // R4 polarity constant 1 and reserved code
      clear_cfg();
      xor_src = 2'd1;
      #2 chk("R4 const one inverts", pin_out, 1'b1);
      @(posedge clk);
      xor_src = 2'd3; sum_en = 5'b00001;
      #2 chk("R4 reserved acts as zero", pin_out, 1'b1);
      @(posedge clk);

      // R5 R6 independent selects
      clear_cfg();
      reg_q = 1; pin_reg = 1; fb_reg = 0;
      #2 chk("R5 pin registered", pin_out, 1'b1);
      chk("R6 fb combinational", fb_out, 1'b0);
      @(posedge clk);
      pin_reg = 0; fb_reg = 1;
      #2 chk("R5 pin combinational", pin_out, 1'b0);
      chk("R6 fb registered", fb_out, 1'b1);
      @(posedge clk);

      // R7 every code
      clear_cfg();
      oe_pin = 2'b10; oe_idx = 3'd4;
      for (int c = 0; c < 8; c++) begin
         oe_src = 3'(c);
         #2 chk("R7 oe code", oe_out, m_oe());
         @(posedge clk);
      end

      // R9 out-of-range indices
      clear_cfg();
      xor_src = 2'd2; xor_idx = 3'd6; oe_src = 3'd4; oe_idx = 3'd7;
      fold_idx = 3'd5; sum_en = 5'b00001;
      #2 chk("R9 xor idx out of range", pin_out, 1'b1);
      chk("R9 oe idx out of range", oe_out, 1'b0);
      chk("R9 fold idx out of range", fold_out, 1'b1);
      @(posedge clk);

      // Random configurations with sparse masks
      for (int it = 0; it < 3000; it++) begin
         for (int p = 0; p < N_PT; p++) begin
            for (int i = 0; i < N_IN; i++) begin
               mpos[p][i] = ($urandom % 24) == 0;
               mneg[p][i] = ($urandom % 24) == 0;
            end
         end
         for (int i = 0; i < N_IN; i++) arr_in[i] = $urandom % 2;
         sum_en   = 5'($urandom);
         chain_en = 1'($urandom);
         chain_in = 1'($urandom);
         reg_q    = 1'($urandom);
         pin_reg  = 1'($urandom);
         fb_reg   = 1'($urandom);
         xor_src  = 2'($urandom);
         oe_src   = 3'($urandom);
         oe_pin   = 2'($urandom);
         xor_idx  = 3'($urandom);
         oe_idx   = 3'($urandom);
         fold_idx = 3'($urandom);
         check_all("rand R1 R2 R4 R9");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule